// File: doc/BRIEF.md
# Binary FSK Baseband Symbol Mapper

This block turns a stream of 32-bit data words into a two-tone sine waveform for a baseband transmit chain. It accepts a word through a valid/ready handshake and sends the word one bit at a time, starting with bit 0. Each bit becomes exactly one full sine cycle of 16-bit two's-complement DAC codes. The tone depends on the bit value. A 1 bit uses a short dwell, which gives the higher tone, and a 0 bit uses a longer dwell, which gives the lower tone.

The tone is set by the dwell: the number of clocks each degree of a 360-step sine table is held. A set up with `dwell_one` about half of `dwell_zero` gives a 1-bit tone roughly twice the 0-bit tone. Every bit starts at degree 0 and ends at degree 359, so the waveform joins with no phase jump at each bit boundary. The sink can stall the waveform with `out_ready`. While the word is being sent, the source sees `in_ready` low.

Top module: `fsk_mapper`

## Requirements
- R1: After reset `out_valid`, `word_done` and `out_last` are low, `out_code` is 0x0000 and `in_ready` is high.
- R2: A word is taken only in a cycle where `in_valid` is high, all four bits of `in_keep` are set and `in_ready` is high. A word whose keep bits are not all set is never taken. `in_ready` stays low from the cycle after acceptance until the last sample of the word has been delivered.
- R3: Bits are sent from bit 0 up to bit 31. The dwell for each bit is `dwell_one` when the bit is 1 and `dwell_zero` when it is 0, sampled when that bit starts.
- R4: Each bit steps the degree index once through 0, 1, …, 359. Each degree is presented for dwell delivered cycles, which gives 360×dwell samples per bit. The next bit starts again at degree 0.
- R5: The code for degree d in 0..180 is trunc(26208·sin(d·π/180)), so 0x0000 at 0 and 180 and 0x6660 at 90. The code for d in 181..359 is the bitwise complement of the code for d−180, which gives 0x999F at 270.
- R6: `word_done` is high exactly while bit 31 of a word is being presented and low for bits 0 to 30.
- R7: `out_last` equals the `in_last` value captured with the word while bit 31 is presented, and is low at all other times.
- R8: While `out_valid` is high and `out_ready` is low, the output code, the degree, the dwell count and the bit position all hold. When `out_ready` returns, the waveform continues with no sample lost or repeated.
- R9: A dwell value of 0 behaves as a dwell of 1, which means one degree step per delivered cycle.
- R10: `out_valid` is high for exactly the samples of an accepted word. In the cycle after the last sample it is low again and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dwell_one | input | 16 | Clocks per degree for a 1 bit |
| dwell_zero | input | 16 | Clocks per degree for a 0 bit |
| in_data | input | 32 | Data word, sent bit 0 first |
| in_keep | input | 4 | Byte keep bits; all must be set for acceptance |
| in_valid | input | 1 | Input word valid |
| in_last | input | 1 | End-of-packet marker for the word |
| in_ready | output | 1 | High when the mapper is idle and can take a word |
| out_code | output | 16 | Two's-complement DAC sample |
| out_valid | output | 1 | Sample valid |
| out_last | output | 1 | End-of-packet marker, high during bit 31 of a marked word |
| out_ready | input | 1 | Sink accepts the sample; low stalls the waveform |
| word_done | output | 1 | High while bit 31 of the word is presented |

## Verification
The bench checks every sample of each word against a model of the degree sequence. It uses four data patterns. An alternating nibble pattern with dwells of 1 and 2 shows whether the tone follows each bit in bit-0-first order. A word with only its outer bits set, run with dwell_zero of 3 and dwell_one of 0, checks bit order at both ends and the treatment of a zero dwell. An all-ones word sent with the last marker checks that `out_last` and `word_done` appear only during bit 31. The alternating word is sent again while `out_ready` drops on every third cycle, to show that a stall holds the phase and loses no sample. A word with incomplete keep bits is offered first, to show that it is refused.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  localparam int DEGREES = 360;
  localparam int HALF    = DEGREES / 2;
  localparam int DEG_W   = $clog2(DEGREES);
  localparam int HI_W    = $clog2(HALF + 1);

  // Truncated amplitude * sin(deg), evaluated at elaboration only.
  function automatic int sine_trunc(input int deg, input int amp);
    real ang;
    real val;
    ang = 3.14159265358979323846 * real'(deg) / real'(HALF);
    val = real'(amp) * $sin(ang);
    return $rtoi(val);
  endfunction
endpackage

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom
  import fsk_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int AMP    = 26208
) (
  input  logic [DEG_W-1:0]  deg,
  output logic [CODE_W-1:0] code
);
  localparam int ROWS = 2 ** HI_W;

  logic [CODE_W-1:0] half_tbl [ROWS];
  logic              mirror;
  logic [HI_W-1:0]   idx;

  // First half of the wave, degrees 0..HALF; unused rows are zero.
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    if (g <= HALF) begin : g_live
      assign half_tbl[g] = CODE_W'(sine_trunc(g, AMP));
    end else begin : g_pad
      assign half_tbl[g] = '0;
    end
  end

  // Second half is the bitwise complement of the first.
  always_comb begin
    mirror = (deg > DEG_W'(HALF));
    idx    = mirror ? HI_W'(deg - DEG_W'(HALF)) : HI_W'(deg);
    code   = mirror ? ~half_tbl[idx] : half_tbl[idx];
  end
endmodule

// File: rtl/fsk_dwell_timer.sv
module fsk_dwell_timer #(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DWELL_W-1:0] load_val,
  input  logic               adv,
  output logic               step
);
  logic [DWELL_W-1:0] period_q, period_d;
  logic [DWELL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    step     = adv && (cnt_q == period_q - DWELL_W'(1));
    period_d = period_q;
    cnt_d    = cnt_q;
    if (load) begin
      period_d = load_val;
      cnt_d    = '0;
    end else if (adv) begin
      cnt_d = step ? '0 : cnt_q + DWELL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= DWELL_W'(1);
      cnt_q    <= '0;
    end else begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period_q); // R3
endmodule

// File: rtl/fsk_bit_sequencer.sv
module fsk_bit_sequencer
  import fsk_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int DWELL_W = 16,
  localparam int KEEP_W = WORD_W / 8,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DWELL_W-1:0] dwell_one,
  input  logic [DWELL_W-1:0] dwell_zero,
  input  logic [WORD_W-1:0]  in_data,
  input  logic [KEEP_W-1:0]  in_keep,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic               out_ready,
  output logic               busy,
  output logic [DEG_W-1:0]   deg,
  output logic               on_last_bit,
  output logic               word_last
);
  logic              busy_q, busy_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              last_q, last_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DEG_W-1:0]  deg_q, deg_d;

  logic accept, adv, step, at_top, bit_end, at_last_bit, word_end, load, next_bit;
  logic [DWELL_W-1:0] raw_dwell, load_val;

  fsk_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .adv(adv), .step(step)
  );

  always_comb begin
    accept      = in_valid && (&in_keep) && !busy_q;
    adv         = busy_q && out_ready;
    at_top      = (deg_q == DEG_W'(DEGREES - 1));
    bit_end     = step && at_top;
    at_last_bit = (bit_q == BIT_W'(WORD_W - 1));
    word_end    = bit_end && at_last_bit;
    load        = accept || (bit_end && !at_last_bit);
    next_bit    = accept ? in_data[0] : word_q[1];
    raw_dwell   = next_bit ? dwell_one : dwell_zero;
    load_val    = (raw_dwell == '0) ? DWELL_W'(1) : raw_dwell;

    busy_d = busy_q;
    word_d = word_q;
    last_d = last_q;
    bit_d  = bit_q;
    deg_d  = deg_q;
    if (accept) begin
      busy_d = 1'b1;
      word_d = in_data;
      last_d = in_last;
      bit_d  = '0;
      deg_d  = '0;
    end else if (adv && step) begin
      deg_d = at_top ? '0 : deg_q + DEG_W'(1);
      if (bit_end) begin
        word_d = word_q >> 1;
        bit_d  = at_last_bit ? '0 : bit_q + BIT_W'(1);
        if (word_end) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      word_q <= '0;
      last_q <= 1'b0;
      bit_q  <= '0;
      deg_q  <= '0;
    end else begin
      busy_q <= busy_d;
      word_q <= word_d;
      last_q <= last_d;
      bit_q  <= bit_d;
      deg_q  <= deg_d;
    end
  end

  assign busy        = busy_q;
  assign deg         = deg_q;
  assign on_last_bit = busy_q && at_last_bit;
  assign word_last   = last_q;

  AST_DEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    deg_q < DEG_W'(DEGREES)); // R4
  AST_BIT_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bit_q != $past(bit_q)) |-> deg_q == '0); // R4
  AST_ACCEPT_NEEDS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(in_valid && (&in_keep))); // R2
endmodule

// File: rtl/fsk_mapper.sv
module fsk_mapper
  import fsk_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int CODE_W  = 16,
  parameter int DWELL_W = 16,
  parameter int AMP     = 26208,
  localparam int KEEP_W = WORD_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DWELL_W-1:0] dwell_one,
  input  logic [DWELL_W-1:0] dwell_zero,
  input  logic [WORD_W-1:0]  in_data,
  input  logic [KEEP_W-1:0]  in_keep,
  input  logic               in_valid,
  input  logic               in_last,
  output logic               in_ready,
  output logic [CODE_W-1:0]  out_code,
  output logic               out_valid,
  output logic               out_last,
  input  logic               out_ready,
  output logic               word_done
);
  logic             busy, on_last_bit, word_last;
  logic [DEG_W-1:0] deg;

  fsk_bit_sequencer #(.WORD_W(WORD_W), .DWELL_W(DWELL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .dwell_one(dwell_one), .dwell_zero(dwell_zero),
    .in_data(in_data), .in_keep(in_keep), .in_valid(in_valid),
    .in_last(in_last), .out_ready(out_ready), .busy(busy), .deg(deg),
    .on_last_bit(on_last_bit), .word_last(word_last)
  );

  fsk_sine_rom #(.CODE_W(CODE_W), .AMP(AMP)) u_rom (
    .deg(deg), .code(out_code)
  );

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign word_done = on_last_bit;
  assign out_last  = on_last_bit && word_last;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_code) && $stable(word_done))); // R8
endmodule

// File: tb/fsk_mapper_test.sv
module fsk_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dwell_one = 16'd1, dwell_zero = 16'd2;
  logic [31:0] in_data = '0;
  logic [3:0]  in_keep = '0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_last, word_done;
  logic [15:0] out_code;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  fsk_mapper uut (
    .clk(clk), .rst_n(rst_n), .dwell_one(dwell_one), .dwell_zero(dwell_zero),
    .in_data(in_data), .in_keep(in_keep), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_code(out_code),
    .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
    .word_done(word_done)
  );

  task automatic check(input string tag, input bit ok, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // R5 reference: truncated first half, complemented second half.
  function automatic logic [15:0] ref_code(input int d);
    real v;
    if (d <= 180) begin
      v = 26208.0 * $sin(3.14159265358979323846 * real'(d) / 180.0);
      return 16'($rtoi(v));
    end
    return ~ref_code(d - 180);
  endfunction

  task automatic t_reset_state();
    check("R1 out_valid", out_valid == 1'b0, 32'(out_valid), 0);
    check("R1 out_code", out_code == 16'h0000, 32'(out_code), 0);
    check("R1 word_done", word_done == 1'b0, 32'(word_done), 0);
    check("R1 out_last", out_last == 1'b0, 32'(out_last), 0);
    check("R1 in_ready", in_ready == 1'b1, 32'(in_ready), 1);
  endtask

  task automatic t_keep_reject();
    int bad;
    bad = 0;
    in_data = 32'hFFFF_FFFF; in_keep = 4'h7; in_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (out_valid !== 1'b0 || in_ready !== 1'b1) bad++;
    end
    in_valid = 1'b0; in_keep = 4'h0;
    check("R2 partial keep refused", bad == 0, 32'(bad), 0);
  endtask

  // Sends one word and compares every sample against the model.
  task automatic run_word(input string name, input logic [31:0] data,
                          input bit last, input logic [15:0] d1,
                          input logic [15:0] d0, input bit stall);
    int b, deg, dw, per, cyc;
    int e_code, e_done, e_last, e_flow, e_ready;
    logic [31:0] a_code, x_code;
    bit fin;
    b = 0; deg = 0; dw = 0; cyc = 0; fin = 0;
    e_code = 0; e_done = 0; e_last = 0; e_flow = 0; e_ready = 0;
    a_code = '0; x_code = '0;
    @(negedge clk);
    dwell_one = d1; dwell_zero = d0;
    in_data = data; in_keep = 4'hF; in_last = last; in_valid = 1'b1;
    out_ready = 1'b1;
    check({"R2 idle ready ", name}, in_ready == 1'b1, 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0; in_keep = 4'h0;
    while (!fin) begin
      per = data[b] ? ((d1 == 0) ? 1 : int'(d1)) : ((d0 == 0) ? 1 : int'(d0));
      if (out_code !== ref_code(deg)) begin
        if (e_code == 0) begin a_code = 32'(out_code); x_code = 32'(ref_code(deg)); end
        e_code++;
      end
      if (word_done !== (b == 31)) e_done++;
      if (out_last !== (last && b == 31)) e_last++;
      if (out_valid !== 1'b1) e_flow++;
      if (in_ready !== 1'b0) e_ready++;
      out_ready = stall ? (cyc % 3 != 2) : 1'b1;
      cyc++;
      if (out_ready) begin
        dw++;
        if (dw == per) begin
          dw = 0; deg++;
          if (deg == 360) begin
            deg = 0; b++;
            if (b == 32) fin = 1;
          end
        end
      end
      @(negedge clk);
      if (cyc > 150000) fin = 1;
    end
    out_ready = 1'b1;
    check({"R3 R4 R5 sample stream ", name}, e_code == 0, a_code, x_code);
    check({"R6 done on bit 31 ", name}, e_done == 0, 32'(e_done), 0);
    check({"R7 last marker ", name}, e_last == 0, 32'(e_last), 0);
    check({"R10 valid during word ", name}, e_flow == 0, 32'(e_flow), 0);
    check({"R2 ready low while busy ", name}, e_ready == 0, 32'(e_ready), 0);
    check({"R10 valid drops after word ", name}, out_valid == 1'b0, 32'(out_valid), 0);
    check({"R10 ready back after word ", name}, in_ready == 1'b1, 32'(in_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_keep_reject();
    // R5 corner values through the reference itself
    check("R5 peak at 90", ref_code(90) == 16'h6660, 32'(ref_code(90)), 32'h6660);
    check("R5 trough at 270", ref_code(270) == 16'h999F, 32'(ref_code(270)), 32'h999F);
    run_word("alt R3", 32'hA5A5_0F0F, 1'b0, 16'd1, 16'd2, 1'b0);
    run_word("ends R9", 32'h8000_0001, 1'b0, 16'd0, 16'd3, 1'b0);
    run_word("ones R7", 32'hFFFF_FFFF, 1'b1, 16'd1, 16'd2, 1'b0);
    run_word("stall R8", 32'hA5A5_0F0F, 1'b1, 16'd1, 16'd2, 1'b1);
    finish_run();
  end
endmodule